// File: doc/BRIEF.md
# Output Drive and Sleep Sequencer

This block decides, cycle by cycle, whether a pipelined common-I/O synchronous memory may drive its shared data bus, and it walks the memory into and out of a low-power sleep state. The access controller beside it reports, for each rising clock edge, whether a read access was started by an address strobe, whether a write cycle was registered, and whether a deselect was executed. The block also takes an asynchronous active-low output enable and an asynchronous active-high sleep request.

Drive follows a double-cycle deselect scheme. A first enable stage records that the device holds a live read. A second, pipelined stage follows it one clock later and is the one that gates the pads. This keeps the bus driven for one extra cycle after a deselect. It also hides the first cycle of a read that begins from the deselected state. Writes clear both stages at once, and the bus then stays released until a new read begins. The sleep request is synchronised first. It then passes through a counter that spends a fixed number of cycles entering and leaving sleep. New accesses are refused throughout that time.

Top module: `bus_drive_sleep_seq`

## Requirements
- R1: After reset, drive_en_o, acc_block_o, asleep_o and err_o are all 0.
- R2: A read started at edge k from the deselected or post-write state keeps drive_en_o at 0 between edges k and k+1 whatever oe_ni is. From edge k+1 on, drive_en_o equals the inverse of oe_ni.
- R3: A deselect at edge d leaves drive_en_o following the output enable until edge d+1. drive_en_o is 0 from edge d+1 on.
- R4: Once the second enable stage is set, drive_en_o follows the inverse of oe_ni combinationally, with no clock edge in between.
- R5: A write registered at edge w forces drive_en_o to 0 from edge w on, regardless of oe_ni. It stays 0 until a new read start, and that read's first cycle is masked as in R2.
- R6: A read start at an edge where a read is already live keeps drive_en_o equal to the inverse of oe_ni, with no masked cycle.
- R7: With the device deselected, sleep_i rising before edge e1 raises acc_block_o from edge e1+2 and asleep_o from edge e1+4. That is two synchroniser cycles plus two entry cycles.
- R8: sleep_i falling before edge f1 drops asleep_o from edge f1+2 and acc_block_o from edge f1+4. That is two synchroniser cycles plus two exit cycles.
- R9: While acc_block_o is 1, rd_start_i, wr_i and desel_i are ignored. A read start during that time produces no drive after wake-up, and any enable state held at entry is discarded.
- R10: While awake and selected, a synchronised sleep request sets err_o and holds the device awake. After a deselect at edge d, err_o is 0 from edge d on, and acc_block_o rises at edge d+1.
- R11: drive_en_o is never 1 while acc_block_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_start_i | input | 1 | Read access started by an address strobe at this edge |
| wr_i | input | 1 | Write cycle registered at this edge |
| desel_i | input | 1 | Deselect executed at this edge (highest priority) |
| oe_ni | input | 1 | Asynchronous active-low output enable |
| sleep_i | input | 1 | Asynchronous active-high sleep request |
| drive_en_o | output | 1 | Data pad drive enable |
| acc_block_o | output | 1 | Sleep sequence active; new accesses refused |
| asleep_o | output | 1 | Fully in sleep |
| err_o | output | 1 | Sleep requested while the device is selected |

## Verification
Directed sequences drive the drive enable through several patterns. A read from idle shows the masked first cycle. A read on top of a live read shows that no cycle is masked. A deselect with the enable held low shows the extra drive cycle that single-cycle deselect would lack. A write between reads shows that the bus stays released until the next read. Sleep entry and exit are timed edge by edge to separate the synchroniser delay from the counter delay. A sleep request made while selected shows that entry waits for the deselect. A long random stream of mutually exclusive controller events, output enable changes and sleep toggles is compared every cycle against a bench model. That stream catches interactions the directed cases miss, such as strobes landing in the exit window.

// File: rtl/bds_pkg.sv
package bds_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ENTER  = 2'd1,
    ST_ASLEEP = 2'd2,
    ST_EXIT   = 2'd3
  } slp_state_e;
endpackage

// File: rtl/bds_sync.sv
module bds_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bds_drive.sv
module bds_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,   // controller events honoured this edge
  input  logic flush_i,    // sleep sequence active: drop all enable state
  input  logic awake_i,
  input  logic rd_start_i,
  input  logic wr_i,
  input  logic desel_i,
  input  logic oe_ni,
  output logic sel_o,
  output logic en1_o,
  output logic en2_o,
  output logic drive_en_o
);
  logic sel_q, en1_q, en2_q;
  logic sel_d, en1_d, en2_d;

  always_comb begin
    sel_d = sel_q;
    en1_d = en1_q;
    en2_d = en1_q;              // pipelined stage trails the first by a cycle
    if (flush_i) begin
      sel_d = 1'b0;
      en1_d = 1'b0;
      en2_d = 1'b0;
    end else if (accept_i) begin
      if (desel_i) begin
        sel_d = 1'b0;
        en1_d = 1'b0;           // en2 keeps en1 for one more cycle
      end else if (wr_i) begin
        sel_d = 1'b1;
        en1_d = 1'b0;
        en2_d = 1'b0;           // write releases bus at once
      end else if (rd_start_i) begin
        sel_d = 1'b1;
        en1_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      en1_q <= 1'b0;
      en2_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      en1_q <= en1_d;
      en2_q <= en2_d;
    end
  end

  assign sel_o      = sel_q;
  assign en1_o      = en1_q;
  assign en2_o      = en2_q;
  assign drive_en_o = en2_q & ~oe_ni & awake_i;
endmodule

// File: rtl/bds_sleep_fsm.sv
module bds_sleep_fsm
  import bds_pkg::*;
#(
  parameter int SLEEP_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,        // synchronised sleep request
  input  logic sel_i,        // device currently selected
  output logic awake_o,
  output logic enter_now_o,
  output logic acc_block_o,
  output logic asleep_o,
  output logic err_o
);
  localparam int CNT_W = (SLEEP_CYC < 2) ? 1 : $clog2(SLEEP_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SLEEP_CYC - 1);

  slp_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign enter_now_o = (st_q == ST_AWAKE) && req_i && !sel_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_AWAKE: if (enter_now_o) begin
        st_d  = ST_ENTER;
        cnt_d = CNT_LOAD;
      end
      ST_ENTER: begin
        if (cnt_q == '0) st_d = ST_ASLEEP;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_ASLEEP: if (!req_i) begin
        st_d  = ST_EXIT;
        cnt_d = CNT_LOAD;
      end
      ST_EXIT: begin
        if (cnt_q == '0) st_d = ST_AWAKE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_AWAKE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign awake_o     = (st_q == ST_AWAKE);
  assign acc_block_o = !awake_o;
  assign asleep_o    = (st_q == ST_ASLEEP);
  assign err_o       = awake_o && req_i && sel_i;
endmodule

// File: rtl/bus_drive_sleep_seq.sv
module bus_drive_sleep_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int SLEEP_CYC   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_start_i,
  input  logic wr_i,
  input  logic desel_i,
  input  logic oe_ni,
  input  logic sleep_i,
  output logic drive_en_o,
  output logic acc_block_o,
  output logic asleep_o,
  output logic err_o
);
  logic req_sync;
  logic sel_w, en1_w, en2_w;
  logic awake_w, enter_now_w;

  bds_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sleep_i),
    .q_o    (req_sync)
  );

  bds_sleep_fsm #(.SLEEP_CYC(SLEEP_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_sync),
    .sel_i       (sel_w),
    .awake_o     (awake_w),
    .enter_now_o (enter_now_w),
    .acc_block_o (acc_block_o),
    .asleep_o    (asleep_o),
    .err_o       (err_o)
  );

  bds_drive u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (awake_w && !enter_now_w),
    .flush_i    (!awake_w),
    .awake_i    (awake_w),
    .rd_start_i (rd_start_i),
    .wr_i       (wr_i),
    .desel_i    (desel_i),
    .oe_ni      (oe_ni),
    .sel_o      (sel_w),
    .en1_o      (en1_w),
    .en2_o      (en2_w),
    .drive_en_o (drive_en_o)
  );
endmodule

// File: rtl/bds_checks.sv
module bds_checks (
  input logic clk_i,
  input logic rst_ni,
  input logic rd_start_i,
  input logic wr_i,
  input logic desel_i,
  input logic drive_en_o,
  input logic acc_block_o,
  input logic asleep_o,
  input logic err_o,
  input logic en1
);
  assert_no_drive_blocked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_block_o |-> !drive_en_o);

  assert_write_releases_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !desel_i && !acc_block_o) |=> !drive_en_o);

  assert_first_cycle_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start_i && !wr_i && !desel_i && !acc_block_o && !en1) |=> !drive_en_o);

  assert_double_deselect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desel_i && !acc_block_o) |=> ##1 !drive_en_o);

  assert_entry_time_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> $past(acc_block_o, 2));

  assert_exit_time_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(acc_block_o) |-> !$past(asleep_o));

  assert_err_holds_awake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !acc_block_o);
endmodule

bind bus_drive_sleep_seq bds_checks u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_start_i  (rd_start_i),
  .wr_i        (wr_i),
  .desel_i     (desel_i),
  .drive_en_o  (drive_en_o),
  .acc_block_o (acc_block_o),
  .asleep_o    (asleep_o),
  .err_o       (err_o),
  .en1         (en1_w)
);

// File: tb/sim_bus_drive_sleep_seq.sv
module sim_bus_drive_sleep_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_start = 1'b0, wr = 1'b0, desel = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic drive_en, acc_block, asleep, err;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_drive_sleep_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_start_i(rd_start), .wr_i(wr),
    .desel_i(desel), .oe_ni(oe_n), .sleep_i(sleep),
    .drive_en_o(drive_en), .acc_block_o(acc_block), .asleep_o(asleep), .err_o(err)
  );

  // reference model: 0 awake, 1 entering, 2 asleep, 3 leaving
  bit m_s1, m_s2, m_sel, m_en1, m_en2;
  int m_st, m_cnt;

  task automatic model_tick();
    bit enter_now, acc;
    enter_now = (m_st == 0) && m_s2 && !m_sel;
    acc = (m_st == 0) && !enter_now;
    if (m_st != 0) begin
      m_sel = 0; m_en1 = 0; m_en2 = 0;
    end else if (acc && desel) begin
      m_en2 = m_en1; m_sel = 0; m_en1 = 0;
    end else if (acc && wr) begin
      m_sel = 1; m_en1 = 0; m_en2 = 0;
    end else if (acc && rd_start) begin
      m_en2 = m_en1; m_sel = 1; m_en1 = 1;
    end else begin
      m_en2 = m_en1;
    end
    case (m_st)
      0: if (enter_now) begin m_st = 1; m_cnt = 1; end
      1: if (m_cnt == 0) m_st = 2; else m_cnt--;
      2: if (!m_s2) begin m_st = 3; m_cnt = 1; end
      default: if (m_cnt == 0) m_st = 0; else m_cnt--;
    endcase
    m_s2 = m_s1;
    m_s1 = sleep;
  endtask

  function automatic logic exp_drive();
    return m_en2 && !oe_n && (m_st == 0);
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_tick();
    @(negedge clk);
  endtask

  task automatic idle();
    rd_start = 0; wr = 0; desel = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1bd5;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "drive_en_o", drive_en, 1'b0);
    chk("R1", "acc_block_o", acc_block, 1'b0);
    chk("R1", "asleep_o", asleep, 1'b0);
    chk("R1", "err_o", err, 1'b0);

    // R2 masked first cycle, R4 async enable
    rd_start = 1; cyc();
    chk("R2", "drive first cycle", drive_en, 1'b0);
    idle(); cyc();
    chk("R2", "drive second cycle", drive_en, 1'b1);
    oe_n = 1; #1;
    chk("R4", "drive oe high", drive_en, 1'b0);
    oe_n = 0; #1;
    chk("R4", "drive oe low", drive_en, 1'b1);
    // R6 back-to-back read
    rd_start = 1; cyc();
    chk("R6", "drive on new read", drive_en, 1'b1);
    idle();
    // R3 double-cycle deselect
    desel = 1; cyc();
    chk("R3", "drive after deselect edge", drive_en, 1'b1);
    idle(); cyc();
    chk("R3", "drive one edge later", drive_en, 1'b0);
    // R5 write releases bus
    rd_start = 1; cyc(); idle(); cyc();
    chk("R5", "drive before write", drive_en, 1'b1);
    wr = 1; cyc(); idle();
    chk("R5", "drive after write", drive_en, 1'b0);
    cyc(); cyc();
    chk("R5", "drive stays off", drive_en, 1'b0);
    rd_start = 1; cyc(); idle();
    chk("R5", "masked read after write", drive_en, 1'b0);
    cyc();
    chk("R5", "drive after read", drive_en, 1'b1);
    desel = 1; cyc(); idle(); cyc();
    // R7 entry timing
    sleep = 1;
    cyc(); chk("R7", "block e1", acc_block, 1'b0);
    cyc(); chk("R7", "block e2", acc_block, 1'b0);
    cyc(); chk("R7", "block e3", acc_block, 1'b1);
    cyc(); chk("R7", "asleep e4", asleep, 1'b0);
    cyc(); chk("R7", "asleep e5", asleep, 1'b1);
    // R9 ignored while blocked
    rd_start = 1; cyc(); idle();
    chk("R9", "drive while asleep", drive_en, 1'b0);
    chk("R11", "drive while blocked", drive_en, 1'b0);
    // R8 exit timing
    sleep = 0;
    cyc(); cyc(); chk("R8", "asleep f2", asleep, 1'b1);
    cyc(); chk("R8", "asleep f3", asleep, 1'b0);
    rd_start = 1;
    cyc(); idle(); chk("R8", "block f4", acc_block, 1'b1);
    cyc(); chk("R8", "block f5", acc_block, 1'b0);
    cyc(); chk("R9", "no drive from ignored read", drive_en, 1'b0);
    // R10 request while selected
    rd_start = 1; cyc(); idle();
    sleep = 1;
    cyc(); cyc();
    chk("R10", "err raised", err, 1'b1);
    cyc(); cyc();
    chk("R10", "held awake", acc_block, 1'b0);
    chk("R10", "err still set", err, 1'b1);
    desel = 1; cyc(); idle();
    chk("R10", "err cleared", err, 1'b0);
    chk("R10", "not yet blocked", acc_block, 1'b0);
    cyc();
    chk("R10", "entry after deselect", acc_block, 1'b1);
    sleep = 0;
    repeat (8) cyc();
    chk("R8", "awake again", acc_block, 1'b0);

    // random phase against model
    for (int i = 0; i < 5000; i++) begin
      int op;
      op = $urandom % 8;
      idle();
      case (op)
        3, 4: rd_start = 1;
        5: wr = 1;
        6: desel = 1;
        default: ;
      endcase
      oe_n = (($urandom % 4) == 0);
      if (($urandom % 40) == 0) sleep = ~sleep;
      #1;
      chk("R4", "random drive_en_o", drive_en, exp_drive());
      cyc();
      chk("R4", "random drive_en_o", drive_en, exp_drive());
      chk("R7", "random acc_block_o", acc_block, m_st != 0);
      chk("R8", "random asleep_o", asleep, m_st == 2);
      chk("R10", "random err_o", err, (m_st == 0) && m_s2 && m_sel);
      if (acc_block) chk("R11", "random blocked drive", drive_en, 1'b0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule